// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block is the control state machine of a single-rank SDRAM controller. It owns the SDRAM control pins (clock enable, chip select, row strobe, column strobe, write enable and the multiplexed address with its auto-precharge bit). From these pins it issues activate, column, refresh and mode-register commands, and it manages the power-down and self-refresh modes. Requests arrive from the internal bus. Two software control bits gate the SDRAM clock enable and the clock run, and a third bit permits automatic power-down.

Accesses use a valid/ready handshake. The requester raises `acc_valid` and holds `acc_write`, `acc_len`, `acc_row` and `acc_col` stable until it sees `acc_ready`. `acc_ready` is high only in a cycle where the sequencer is idle and has picked the access. The fields are captured on that edge. The other requests (`sleep_req`, `slfrsh_req`, `refresh_req`, `enable_req`) are plain levels that the sequencer samples; their source drops them once it sees the command. Each column command is signalled by `beat_ack`, and `acc_done` marks the end of the precharge wait.

Command codes on {cs_n, ras_n, cas_n, we_n}: NOP 0111, ACT 0011, READ 0101, WRITE 0100, REFRESH 0001, MODE SET 0000. On column commands the address carries the column in its low bits and bit 10 is the auto-precharge flag. On ACT it carries the row. On MODE SET it carries `MRS_CODE`. Otherwise it is zero.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the sequencer is in clock-stopped self-refresh: `sd_cke`=0, `sd_clk_on`=0, NOP. It stays there until `sw_cke_en` and `sw_clk_run` are both 1 while `sleep_req` and `slfrsh_req` are both 0.
- R2: Leaving either self-refresh state raises `sd_cke` and drives NOP for exactly `XSR_CYC` cycles, then returns to idle.
- R3: From idle the exit is chosen by priority, highest first: sleep, self-refresh, clock-enable or clock-run cleared, refresh, new-enable, new-access, auto power-down. Idle with no condition holds with NOP.
- R4: Refresh (0001) and mode set (0000, address `MRS_CODE`) each last one cycle and return to idle.
- R5: An accepted access (`acc_ready`=1 in idle) issues ACT with the row on the address in the next cycle.
- R6: After ACT there follow `acc_len`+1 column commands in consecutive cycles: READ 0101 or WRITE 0100, column on the address, with `beat_ack`=1 in each.
- R7: Address bit 10 is 1 on the final column command only. With `acc_len`=0, the single command carries it.
- R8: After the final column command, NOP is driven for `TRP_CYC` cycles, with `acc_done`=1 in the last of them, and then the sequencer is idle.
- R9: Auto power-down (`sd_cke`=0, NOP) is entered from idle only when `sw_apd_en`=1 and no other idle condition is present.
- R10: Power-down returns to idle with `sd_cke`=1 on the cycle after any of `sleep_req`, `refresh_req`, `enable_req`, `acc_valid` is seen, or after `sw_apd_en` is cleared.
- R11: A cleared `sw_cke_en` or `sw_clk_run` takes idle into a blocked state. In that state `sd_cke`=0, `sd_clk_on` follows `sw_clk_run`, and only NOP is driven regardless of requests, until both bits are 1 again, when it returns to idle.
- R12: Sleep or self-refresh entry drives REFRESH with `sd_cke`=0 for one cycle. Sleep then goes to clock-stopped self-refresh. Self-refresh keeps `sd_cke`=0 while `slfrsh_req` holds. It leaves through R2 when `slfrsh_req` is 0 and `sw_cke_en` is 1, and goes to the clock-stopped state on `sleep_req` or a cleared `sw_clk_run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Enter sleep (clock-stopped self-refresh) |
| slfrsh_req | input | 1 | Hold self-refresh |
| refresh_req | input | 1 | Auto-refresh request |
| enable_req | input | 1 | New-enable, issues mode set |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access accepted this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_len | input | LEN_W | Beats minus one |
| acc_row | input | ADDR_W | Row address |
| acc_col | input | COL_W | Column address |
| sw_cke_en | input | 1 | Software clock-enable permit |
| sw_clk_run | input | 1 | Software clock-run permit |
| sw_apd_en | input | 1 | Automatic power-down permit |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_clk_on | output | 1 | SDRAM clock running |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_addr | output | ADDR_W | Multiplexed address, bit 10 auto-precharge |
| beat_ack | output | 1 | Column command issued |
| acc_done | output | 1 | Access finished |

## Verification
Every pin is a decode of the state register. `acc_ready` and, in the blocked state, `sd_clk_on` also look at the current inputs. So a request seen at one edge shows its command during the following cycle: ACT comes one cycle after `acc_ready`, and the first column command one cycle after that. The bench drives inputs at the falling edge and samples one time unit later. A behavioural model predicts the full pin vector for that cycle and is advanced once per edge. Served requests are withdrawn only after the edge that consumed them. This lets the exact cycle of each ACT, column beat, precharge NOP, `acc_done` and wake-up be compared on every clock.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  typedef enum logic [3:0] {
    ST_CLKSTOP, ST_XSR, ST_IDLE, ST_PDN, ST_HALT, ST_SLPEN, ST_SREN,
    ST_SRF, ST_REF, ST_MRS, ST_ACT, ST_COL, ST_PRE
  } seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_ACT = 4'b0011;
  localparam logic [3:0] CMD_RD  = 4'b0101;
  localparam logic [3:0] CMD_WR  = 4'b0100;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  localparam int AP_BIT = 10;

  // idle request vector positions, index 0 is highest priority
  localparam int RQ_SLEEP = 0;
  localparam int RQ_SRF   = 1;
  localparam int RQ_HALT  = 2;
  localparam int RQ_REF   = 3;
  localparam int RQ_EN    = 4;
  localparam int RQ_ACC   = 5;
  localparam int RQ_APD   = 6;
  localparam int RQ_N     = 7;
endpackage

// File: rtl/sdram_idle_arb.sv
module sdram_idle_arb #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) grant = N'(1) << i;
    end
  end

  // R3: at most one exit chosen
  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R3: a pending request always yields a choice
  p_grant_any_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ($countones(grant) == 1));
endmodule

// File: rtl/sdram_seq_cnt.sv
module sdram_seq_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R8: counter never wraps below zero
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !zero);
endmodule

// File: rtl/sdram_pin_enc.sv
module sdram_pin_enc
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 9,
  parameter logic [ADDR_W-1:0] MRS_CODE = 'h032
) (
  input  seq_state_e        st,
  input  logic              wr,
  input  logic              last,
  input  logic              clk_run,
  input  logic [ADDR_W-1:0] row,
  input  logic [COL_W-1:0]  col,
  output logic              cke,
  output logic              clk_on,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    cke    = 1'b1;
    clk_on = 1'b1;
    cmd    = CMD_NOP;
    addr   = '0;
    unique case (st)
      ST_CLKSTOP: begin cke = 1'b0; clk_on = 1'b0; end
      ST_PDN, ST_SRF: cke = 1'b0;
      ST_HALT: begin cke = 1'b0; clk_on = clk_run; end
      ST_SLPEN, ST_SREN: begin cke = 1'b0; cmd = CMD_REF; end
      ST_REF: cmd = CMD_REF;
      ST_MRS: begin cmd = CMD_MRS; addr = MRS_CODE; end
      ST_ACT: begin cmd = CMD_ACT; addr = row; end
      ST_COL: begin
        cmd = wr ? CMD_WR : CMD_RD;
        addr[COL_W-1:0] = col;
        addr[AP_BIT]    = last;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int COL_W   = 9,
  parameter int LEN_W   = 3,
  parameter int TRP_CYC = 2,
  parameter int XSR_CYC = 4,
  parameter logic [ADDR_W-1:0] MRS_CODE = 'h032
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              slfrsh_req,
  input  logic              refresh_req,
  input  logic              enable_req,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_write,
  input  logic [LEN_W-1:0]  acc_len,
  input  logic [ADDR_W-1:0] acc_row,
  input  logic [COL_W-1:0]  acc_col,
  input  logic              sw_cke_en,
  input  logic              sw_clk_run,
  input  logic              sw_apd_en,
  output logic              sd_cke,
  output logic              sd_clk_on,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              beat_ack,
  output logic              acc_done
);
  localparam int WAIT_MAX = (TRP_CYC > XSR_CYC) ? TRP_CYC : XSR_CYC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  seq_state_e st, nxt;
  logic [RQ_N-1:0] req, grant;
  logic [ADDR_W-1:0] row_q;
  logic [COL_W-1:0]  col_q;
  logic wr_q, beat_zero, wait_zero, wait_load, hs;
  logic [WAIT_W-1:0] wait_val;
  logic [3:0] cmd;
  logic wake, sr_leave, stop_leave;

  assign req[RQ_SLEEP] = sleep_req;
  assign req[RQ_SRF]   = slfrsh_req;
  assign req[RQ_HALT]  = !sw_cke_en || !sw_clk_run;
  assign req[RQ_REF]   = refresh_req;
  assign req[RQ_EN]    = enable_req;
  assign req[RQ_ACC]   = acc_valid;
  assign req[RQ_APD]   = sw_apd_en;

  sdram_idle_arb #(.N(RQ_N)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .grant(grant)
  );

  assign acc_ready  = (st == ST_IDLE) && grant[RQ_ACC];
  assign hs         = acc_valid && acc_ready;
  assign wake       = sleep_req || refresh_req || enable_req || acc_valid || !sw_apd_en;
  assign stop_leave = sw_cke_en && sw_clk_run && !sleep_req && !slfrsh_req;
  assign sr_leave   = !slfrsh_req && sw_cke_en;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_CLKSTOP: if (stop_leave) nxt = ST_XSR;
      ST_XSR:     if (wait_zero) nxt = ST_IDLE;
      ST_IDLE: begin
        if      (grant[RQ_SLEEP]) nxt = ST_SLPEN;
        else if (grant[RQ_SRF])   nxt = ST_SREN;
        else if (grant[RQ_HALT])  nxt = ST_HALT;
        else if (grant[RQ_REF])   nxt = ST_REF;
        else if (grant[RQ_EN])    nxt = ST_MRS;
        else if (grant[RQ_ACC])   nxt = ST_ACT;
        else if (grant[RQ_APD])   nxt = ST_PDN;
      end
      ST_PDN:   if (wake) nxt = ST_IDLE;
      ST_HALT:  if (sw_cke_en && sw_clk_run) nxt = ST_IDLE;
      ST_SLPEN: nxt = ST_CLKSTOP;
      ST_SREN:  nxt = ST_SRF;
      ST_SRF: begin
        if (sleep_req || !sw_clk_run) nxt = ST_CLKSTOP;
        else if (sr_leave)            nxt = ST_XSR;
      end
      ST_REF, ST_MRS: nxt = ST_IDLE;
      ST_ACT: nxt = ST_COL;
      ST_COL: if (beat_zero) nxt = ST_PRE;
      ST_PRE: if (wait_zero) nxt = ST_IDLE;
      default: nxt = ST_CLKSTOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_CLKSTOP;
    else        st <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      wr_q  <= 1'b0;
    end else if (hs) begin
      row_q <= acc_row;
      col_q <= acc_col;
      wr_q  <= acc_write;
    end
  end

  sdram_seq_cnt #(.W(LEN_W)) u_beats (
    .clk(clk), .rst_n(rst_n), .load(hs), .load_val(acc_len),
    .dec((st == ST_COL) && !beat_zero), .zero(beat_zero)
  );

  assign wait_load = (nxt != st) && ((nxt == ST_XSR) || (nxt == ST_PRE));
  assign wait_val  = (nxt == ST_XSR) ? WAIT_W'(XSR_CYC - 1) : WAIT_W'(TRP_CYC - 1);

  sdram_seq_cnt #(.W(WAIT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(wait_load), .load_val(wait_val),
    .dec(((st == ST_XSR) || (st == ST_PRE)) && !wait_zero), .zero(wait_zero)
  );

  sdram_pin_enc #(.ADDR_W(ADDR_W), .COL_W(COL_W), .MRS_CODE(MRS_CODE)) u_enc (
    .st(st), .wr(wr_q), .last(beat_zero), .clk_run(sw_clk_run),
    .row(row_q), .col(col_q), .cke(sd_cke), .clk_on(sd_clk_on),
    .cmd(cmd), .addr(sd_addr)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign beat_ack = (st == ST_COL);
  assign acc_done = (st == ST_PRE) && wait_zero;

  // R4: refresh and mode set are single-cycle commands
  p_single_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF || cmd == CMD_MRS) |=> (cmd == CMD_NOP));
  // R5: activate is followed directly by a column beat
  p_act_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |=> beat_ack);
  // R7: a beat without auto-precharge is never the last
  p_more_beats_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ack && !sd_addr[AP_BIT]) |=> beat_ack);
  // R8: the precharging beat is followed by NOP wait
  p_ap_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ack && sd_addr[AP_BIT]) |=> (!beat_ack && cmd == CMD_NOP));
  // R11: with clock enable low only NOP or self-refresh entry appear
  p_cke_low_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cke |-> (cmd == CMD_NOP || cmd == CMD_REF));
  // R5: the handshake only happens with a request present
  p_ready_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> acc_valid);
endmodule

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;
  localparam int ADDR_W  = 13;
  localparam int COL_W   = 9;
  localparam int LEN_W   = 3;
  localparam int TRP_CYC = 2;
  localparam int XSR_CYC = 4;
  localparam logic [ADDR_W-1:0] MRS_CODE = 'h032;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_REF = 4'b0001, C_MRS = 4'b0000;

  localparam int P_STOP = 0, P_XSR = 1, P_IDLE = 2, P_PDN = 3, P_HALT = 4,
                 P_SLPEN = 5, P_SREN = 6, P_SRF = 7, P_REF = 8, P_MRS = 9,
                 P_ACT = 10, P_COL = 11, P_PRE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 0, slfrsh_req = 0, refresh_req = 0, enable_req = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [LEN_W-1:0]  acc_len = '0;
  logic [ADDR_W-1:0] acc_row = '0;
  logic [COL_W-1:0]  acc_col = '0;
  logic sw_cke_en = 0, sw_clk_run = 0, sw_apd_en = 0;
  logic acc_ready, sd_cke, sd_clk_on, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [ADDR_W-1:0] sd_addr;
  logic beat_ack, acc_done;

  int checks = 0, fails = 0, cycles = 0;
  int m = P_STOP, m_cnt = 0, m_beats = 0;
  logic m_wr = 0;
  logic [ADDR_W-1:0] m_row = '0;
  logic [COL_W-1:0]  m_col = '0;

  always #5 clk = ~clk;

  sdram_cmd_seq #(.ADDR_W(ADDR_W), .COL_W(COL_W), .LEN_W(LEN_W),
    .TRP_CYC(TRP_CYC), .XSR_CYC(XSR_CYC), .MRS_CODE(MRS_CODE)) i_sdram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .slfrsh_req(slfrsh_req),
    .refresh_req(refresh_req), .enable_req(enable_req), .acc_valid(acc_valid),
    .acc_ready(acc_ready), .acc_write(acc_write), .acc_len(acc_len),
    .acc_row(acc_row), .acc_col(acc_col), .sw_cke_en(sw_cke_en),
    .sw_clk_run(sw_clk_run), .sw_apd_en(sw_apd_en), .sd_cke(sd_cke),
    .sd_clk_on(sd_clk_on), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
    .beat_ack(beat_ack), .acc_done(acc_done)
  );

  task automatic check(input string tag, input logic [ADDR_W+8:0] act, input logic [ADDR_W+8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cycles, act, exp);
    end
  endtask

  // one clock: called at a falling edge with the inputs already set
  task automatic step();
    logic [3:0] ecmd;
    logic ecke, eclk, eack, edone, erdy, last;
    logic [ADDR_W-1:0] eaddr;
    int pick, nm;
    string tag;
    bit srv_ref, srv_en, srv_acc;
    #1;
    pick = 7;
    if      (sleep_req)                pick = 0;
    else if (slfrsh_req)               pick = 1;
    else if (!sw_cke_en || !sw_clk_run) pick = 2;
    else if (refresh_req)              pick = 3;
    else if (enable_req)               pick = 4;
    else if (acc_valid)                pick = 5;
    else if (sw_apd_en)                pick = 6;
    ecke = 1; eclk = 1; ecmd = C_NOP; eaddr = '0; eack = 0; edone = 0; erdy = 0;
    srv_ref = 0; srv_en = 0; srv_acc = 0; nm = m; tag = "R3";
    case (m)
      P_STOP: begin
        ecke = 0; eclk = 0; tag = "R1";
        if (sw_cke_en && sw_clk_run && !sleep_req && !slfrsh_req) begin nm = P_XSR; m_cnt = XSR_CYC; end
      end
      P_XSR: begin
        tag = "R2";
        if (m_cnt == 1) nm = P_IDLE; else m_cnt--;
      end
      P_IDLE: begin
        case (pick)
          0: nm = P_SLPEN;
          1: nm = P_SREN;
          2: nm = P_HALT;
          3: begin nm = P_REF; srv_ref = 1; end
          4: begin nm = P_MRS; srv_en = 1; end
          5: begin
            nm = P_ACT; erdy = 1; srv_acc = 1; tag = "R5";
            m_wr = acc_write; m_row = acc_row; m_col = acc_col; m_beats = int'(acc_len);
          end
          6: begin nm = P_PDN; tag = "R9"; end
          default: ;
        endcase
      end
      P_PDN: begin
        ecke = 0; tag = "R9";
        if (sleep_req || refresh_req || enable_req || acc_valid || !sw_apd_en) begin
          nm = P_IDLE; tag = "R10";
        end
      end
      P_HALT: begin
        ecke = 0; eclk = sw_clk_run; tag = "R11";
        if (sw_cke_en && sw_clk_run) nm = P_IDLE;
      end
      P_SLPEN: begin ecke = 0; ecmd = C_REF; tag = "R12"; nm = P_STOP; end
      P_SREN:  begin ecke = 0; ecmd = C_REF; tag = "R12"; nm = P_SRF; end
      P_SRF: begin
        ecke = 0; tag = "R12";
        if (sleep_req || !sw_clk_run) nm = P_STOP;
        else if (!slfrsh_req && sw_cke_en) begin nm = P_XSR; m_cnt = XSR_CYC; end
      end
      P_REF: begin ecmd = C_REF; tag = "R4"; nm = P_IDLE; end
      P_MRS: begin ecmd = C_MRS; eaddr = MRS_CODE; tag = "R4"; nm = P_IDLE; end
      P_ACT: begin ecmd = C_ACT; eaddr = m_row; tag = "R5"; nm = P_COL; end
      P_COL: begin
        last = (m_beats == 0);
        ecmd = m_wr ? C_WR : C_RD;
        eaddr = ADDR_W'(m_col);
        eaddr[10] = last;
        eack = 1;
        tag = last ? "R7" : "R6";
        if (last) begin nm = P_PRE; m_cnt = TRP_CYC; end else m_beats--;
      end
      P_PRE: begin
        tag = "R8"; edone = (m_cnt == 1);
        if (m_cnt == 1) nm = P_IDLE; else m_cnt--;
      end
      default: ;
    endcase
    if (!rst_n) nm = P_STOP;
    check(tag,
      {sd_cke, sd_clk_on, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, beat_ack, acc_done, acc_ready},
      {ecke, eclk, ecmd, eaddr, eack, edone, erdy});
    m = nm;
    @(posedge clk);
    #1;
    cycles++;
    if (srv_ref) refresh_req = 0;
    if (srv_en)  enable_req = 0;
    if (srv_acc) acc_valid = 0;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic access(input logic wr, input int len, input int row, input int col);
    acc_write = wr; acc_len = LEN_W'(len);
    acc_row = ADDR_W'(row); acc_col = COL_W'(col);
    acc_valid = 1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: state during and after reset
    run(3);
    rst_n = 1;
    check("R1 reset", {sd_cke, sd_clk_on, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n},
          {1'b0, 1'b0, C_NOP});
    sw_cke_en = 1; run(3);           // R1: clock-run still clear, stays
    sw_clk_run = 1; run(8);          // R2: exit to idle
    refresh_req = 1; run(3);         // R4
    enable_req = 1; run(3);          // R4
    access(0, 0, 'h1abc, 'h0f3); run(8);   // R5 R7 R8 single read
    access(1, 3, 'h0155, 'h1f0); run(10);  // R6 R7 R8 burst write
    refresh_req = 1; enable_req = 1; access(0, 1, 'h0777, 'h012); run(12); // R3 order
    sw_apd_en = 1; run(5);           // R9
    access(1, 0, 'h0020, 'h040); run(9);   // R10 wake on access
    run(3);
    refresh_req = 1; run(4);         // R10 wake on refresh
    sw_apd_en = 0; run(3);           // R10 apd cleared
    sw_cke_en = 0; refresh_req = 1; run(4); // R11 blocked, request ignored
    sw_clk_run = 0; run(2);          // R11 clock follows run bit
    sw_cke_en = 1; sw_clk_run = 1; run(4); // R11 release, refresh served
    slfrsh_req = 1; access(0, 0, 'h3, 'h4); run(5); // R12 self-refresh beats access
    slfrsh_req = 0; run(10);         // R2 exit, then access
    sleep_req = 1; run(4);           // R12 sleep to clock stop
    sleep_req = 0; run(8);           // R1 R2 wake
    slfrsh_req = 1; run(3);
    sw_clk_run = 0; slfrsh_req = 0; run(3); // R12 clock stop from self-refresh
    sw_clk_run = 1; run(7);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule